// File: doc/BRIEF.md
# SPI Controller Interrupt Register Block

This block gathers seven event sources of an SPI controller into a sticky status register and gates them with a mask to drive one level-sensitive interrupt line. Software clears a status bit by writing a one to it. The mask is never written directly. A set-port turns mask bits on, a clear-port turns them off, and a read-only mirror shows the result.

A watermark register produces one of the seven sources, the transmit-FIFO low-water event. The event is present whenever the transmit FIFO fill level, which arrives on a port, is below the programmed watermark. The shift engine and the FIFO storage are outside this block. The other event conditions arrive as a vector of inputs.

Register map, in bytes: 0x04 status (read, write-one-to-clear), 0x08 mask set (write), 0x0C mask clear (write), 0x10 mask (read), 0x28 watermark (read/write). All four interrupt registers use the same bit layout in bits [6:0]:
- bit 1: mode fault
- bit 2: transmit low-water
- bit 3: transmit full
- bit 4: receive not empty

Top module: `spi_irq_regs`

## Requirements
- R1: After reset, status reads 0x00, mask reads 0x00, watermark reads 1 and `irq_o` is low.
- R2: An event input high at a clock edge sets the matching status bit at that edge. The bit stays set after the input falls, until software clears it.
- R3: A write to 0x04 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. If an event input is still high in the cycle of the clear, its bit stays set.
- R4: A write to 0x08 sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: A write to 0x0C clears each mask bit whose data bit is 1. Writing 0x7F clears the whole mask.
- R6: Reading 0x10 returns the mask. A write to 0x10 has no effect. Reading 0x08 or 0x0C returns 0.
- R7: The watermark at 0x28 holds LVL_W bits and reads back what was written. The bit 2 event is high exactly when `tx_level_i` is below the watermark. `src_i[2]` is ignored.
- R8: `irq_o` is high exactly when some status bit and its mask bit are both 1. It follows register changes with no added delay.
- R9: Write data bits above bit 6 are ignored by 0x04, 0x08 and 0x0C. Status and mask read as 0 above bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| src_i | input | 7 | Event inputs, bit 2 unused |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench clears a status bit while its event input is still high. A design that gave the clear priority would drop that event, and the bit would read 0.

It drives `src_i[2]` while the FIFO level is at or above the watermark. A design that forwarded this input would set bit 2 falsely. It also drives the level exactly at the watermark, where a `<=` comparison would raise the low-water event.

It writes to the read-only mask mirror and writes upper data bits. A design that decoded these writes would change the mask.

It toggles the mask against a pending status bit. A design that did not qualify the interrupt with the mask, or that used only the mask, would show `irq_o` at the wrong level.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_SRC  = 7;
  localparam int SRC_TXLW = 2;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_MSET = 'h08;
  localparam int OFS_MCLR = 'h0C;
  localparam int OFS_MASK = 'h10;
  localparam int OFS_WMRK = 'h28;
endpackage

// File: rtl/spi_irq_status.sv
module spi_irq_status import spi_irq_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] stat_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // new events win over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= (stat_q[i] & ~clr_i[i]) | set_i[i];
    end

    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_q[i] && !clr_i[i] |=> stat_q[i]);
    assert_event_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_q[i]);
    assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !set_i[i] |=> !stat_q[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask import spi_irq_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_i) & ~clr_i;
  end

  assign mask_o = mask_q;

  assert_mask_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((mask_q & $past(set_i)) == $past(set_i)));
  assert_mask_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((mask_q & $past(clr_i)) == '0));
  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|set_i) && !(|clr_i) |=> $stable(mask_q));
endmodule

// File: rtl/spi_irq_wmark.sv
module spi_irq_wmark #(
  parameter int LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [LVL_W-1:0] wdata_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] wm_o,
  output logic             low_o
);
  logic [LVL_W-1:0] wm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wm_q <= LVL_W'(1);
    else if (wr_i) wm_q <= wdata_i;
  end

  assign wm_o  = wm_q;
  assign low_o = level_i < wm_q;

  assert_wm_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> wm_q == $past(wdata_i));
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs import spi_irq_pkg::*; #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 128,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [LVL_W-1:0]   tx_level_i,
  output logic               irq_o
);
  logic sel_stat, sel_mset, sel_mclr, sel_mask, sel_wmrk;
  logic [NUM_SRC-1:0] wbits, stat_clr, mask_set, mask_clr, events, stat, mask;
  logic [LVL_W-1:0]   wm;
  logic               tx_low;
  logic               wdata_unused;

  assign sel_stat = addr_i == ADDR_W'(OFS_STAT);
  assign sel_mset = addr_i == ADDR_W'(OFS_MSET);
  assign sel_mclr = addr_i == ADDR_W'(OFS_MCLR);
  assign sel_mask = addr_i == ADDR_W'(OFS_MASK);
  assign sel_wmrk = addr_i == ADDR_W'(OFS_WMRK);

  assign wbits        = wdata_i[NUM_SRC-1:0];
  assign wdata_unused = ^wdata_i[DATA_W-1:NUM_SRC];
  assign stat_clr     = (wr_en_i && sel_stat) ? wbits : '0;
  assign mask_set     = (wr_en_i && sel_mset) ? wbits : '0;
  assign mask_clr     = (wr_en_i && sel_mclr) ? wbits : '0;

  always_comb begin
    events           = src_i;
    events[SRC_TXLW] = tx_low;
  end

  spi_irq_wmark #(.LVL_W(LVL_W)) u_wmark (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && sel_wmrk),
    .wdata_i (wdata_i[LVL_W-1:0]),
    .level_i (tx_level_i),
    .wm_o    (wm),
    .low_o   (tx_low)
  );

  spi_irq_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (events),
    .clr_i  (stat_clr),
    .stat_o (stat)
  );

  spi_irq_mask u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mask_set),
    .clr_i  (mask_clr),
    .mask_o (mask)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_stat)      rdata_o = DATA_W'(stat);
    else if (sel_mask) rdata_o = DATA_W'(mask);
    else if (sel_wmrk) rdata_o = DATA_W'(wm);
  end

  assign irq_o = |(stat & mask);

  assert_irq_needs_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|mask) && (|stat));
  assert_txlow_ignores_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_low && !stat[SRC_TXLW] && !stat_clr[SRC_TXLW] |=> !stat[SRC_TXLW]);
endmodule

// File: tb/spi_irq_regs_bench.sv
`timescale 1ns/1ps
module spi_irq_regs_bench;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 8;
  localparam int NV     = 6;
  // {src, level, expected status}
  localparam logic [21:0] VECS [0:NV-1] = '{
    {7'h01, 8'd5,   7'h01},
    {7'h7F, 8'd5,   7'h7B},
    {7'h00, 8'd0,   7'h04},
    {7'h12, 8'd3,   7'h12},
    {7'h48, 8'd0,   7'h4C},
    {7'h20, 8'd128, 7'h20}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [6:0]        src = '0;
  logic [LVL_W-1:0]  lvl = 8'd64;
  logic              irq;
  int                checks = 0;
  int                errors = 0;
  logic [DATA_W-1:0] v;

  always #10 clk = ~clk;

  spi_irq_regs u_spi_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .tx_level_i(lvl), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1 d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    rd('h04, v); chk("R1 status", v, 0);
    rd('h10, v); chk("R1 mask", v, 0);
    rd('h28, v); chk("R1 watermark", v, 1);
    chk("R1 irq", {31'd0, irq}, 0);

    // vector table: R2 and R7 event capture
    for (int k = 0; k < NV; k++) begin
      wr('h04, 32'h7F);
      @(negedge clk); src = VECS[k][21:15]; lvl = VECS[k][14:7];
      @(negedge clk); src = '0; lvl = 8'd64;
      rd('h04, v); chk("R2/R7 vector", v, {25'd0, VECS[k][6:0]});
    end

    // R2 sticky after input drops
    wr('h04, 32'h7F);
    @(negedge clk); src = 7'h02;
    @(negedge clk); src = '0;
    repeat (3) tick();
    rd('h04, v); chk("R2 sticky", v, 32'h02);

    // R3 write-one-to-clear
    wr('h04, 32'h00); rd('h04, v); chk("R3 zero write", v, 32'h02);
    wr('h04, 32'h02); rd('h04, v); chk("R3 clear", v, 0);
    @(negedge clk); src = 7'h11;
    @(negedge clk); src = '0;
    wr('h04, 32'h01); rd('h04, v); chk("R3 partial", v, 32'h10);
    wr('h04, 32'h7F);
    @(negedge clk); src = 7'h10;
    wr('h04, 32'h10); rd('h04, v); chk("R3 event persists", v, 32'h10);
    @(negedge clk); src = '0;
    wr('h04, 32'h10); rd('h04, v); chk("R3 cleared after drop", v, 0);

    // R9 upper bits ignored on status clear
    @(negedge clk); src = 7'h08;
    @(negedge clk); src = '0;
    wr('h04, 32'hFFFF_FF80); rd('h04, v); chk("R9 status upper bits", v, 32'h08);
    wr('h04, 32'h7F);

    // R4 mask set
    wr('h08, 32'h05); rd('h10, v); chk("R4 set", v, 32'h05);
    wr('h08, 32'h02); rd('h10, v); chk("R4 accumulate", v, 32'h07);
    // R5 mask clear
    wr('h0C, 32'h04); rd('h10, v); chk("R5 clear one", v, 32'h03);
    wr('h0C, 32'h7F); rd('h10, v); chk("R5 clear all", v, 0);
    // R6 mirror read-only, write-only registers read 0
    wr('h10, 32'h7F); rd('h10, v); chk("R6 mirror write ignored", v, 0);
    wr('h08, 32'h30);
    rd('h08, v); chk("R6 set port reads 0", v, 0);
    rd('h0C, v); chk("R6 clear port reads 0", v, 0);
    rd('h10, v); chk("R6 mirror", v, 32'h30);
    wr('h0C, 32'h7F);
    // R9 upper bits ignored on mask set
    wr('h08, 32'hFFFF_FF80); rd('h10, v); chk("R9 mask upper bits", v, 0);

    // R7 watermark
    wr('h28, 32'd16); rd('h28, v); chk("R7 readback", v, 16);
    wr('h04, 32'h7F);
    @(negedge clk); lvl = 8'd16; src = 7'h04;
    tick();
    rd('h04, v); chk("R7 level equal, src ignored", v, 0);
    @(negedge clk); lvl = 8'd15; src = '0;
    @(negedge clk); lvl = 8'd64;
    rd('h04, v); chk("R7 below watermark", v, 32'h04);
    wr('h04, 32'h7F);

    // R8 interrupt gating
    @(negedge clk); src = 7'h08;
    @(negedge clk); src = '0;
    #1 chk("R8 unmasked low", {31'd0, irq}, 0);
    wr('h08, 32'h08);
    #1 chk("R8 masked high", {31'd0, irq}, 1);
    wr('h04, 32'h08);
    #1 chk("R8 cleared low", {31'd0, irq}, 0);
    wr('h08, 32'h10);
    @(negedge clk); src = 7'h10;
    @(negedge clk); src = '0;
    #1 chk("R8 event to irq", {31'd0, irq}, 1);
    wr('h0C, 32'h7F);
    #1 chk("R8 mask off", {31'd0, irq}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule